// File: doc/BRIEF.md
# Composite video sync generator

This block produces the two control bits that feed a resistor-network monochrome composite video output. `sync_o` selects between the 0 V sync tip and the black pedestal. `video_o` lifts the output from black to white. All timing comes from a fixed-rate system clock, scaled by a cycles-per-microsecond parameter.

Each field is progressive and shortened to `LINES_PER_FIELD` scanlines, 250 by default. Every scanline is 64 µs long, which gives a 15.625 kHz line rate. Each line opens with a 2 µs sync tip and a 4 µs back porch at black. A 52 µs active window follows, and then 6 µs of forced black.

Between fields the block emits a vertical interval of three groups of pulses. The first group is short equalizing pulses, the second is broad pulses, and the third is short equalizing pulses again. Reset starts the block at the head of this vertical interval.

A pixel source connects through three signals:
- `line_start_o` marks the first cycle of each scanline.
- `line_count_o` gives the index of the current scanline.
- `active_o` marks the active window.

The pixel source drives `pixel_i`. The block gates `pixel_i` onto `video_o` only inside the active window.

Top module: `cvs_sync_gen`

## Requirements
- R1: During the field, successive scanlines start exactly 64·C clock cycles apart, where C is `CYCLES_PER_US`.
- R2: Each scanline holds `sync_o` low for its first 2·C cycles, then holds it high for the rest of the line.
- R3: `active_o` is high exactly for line cycles 6·C through 58·C−1, counted from the line's first cycle (cycle 0). It is low everywhere else, including the whole vertical interval.
- R4: `video_o` equals `pixel_i` while `active_o` is high, and is 0 in every other cycle, whatever the value of `pixel_i`.
- R5: The vertical interval opens with `PULSES_PER_GROUP` (6) short pulses. Each pulse is `sync_o` low for 2·C cycles, then high for 31·C cycles.
- R6: Six broad pulses follow. Each is `sync_o` low for 27·C cycles, then high for 4·C cycles.
- R7: Six more short pulses close the vertical interval, with the same 2·C low / 31·C high shape as in R5. The first scanline starts in the cycle right after the last of these pulses ends.
- R8: When reset is released, the block begins at the first short pulse of the vertical interval. It runs a full vertical interval before scanline 0.
- R9: After scanline `LINES_PER_FIELD`−1 ends, the next cycle starts a new vertical interval. The frame therefore repeats every 6·(33+31+33)·C + `LINES_PER_FIELD`·64·C cycles.
- R10: `line_start_o` is high for exactly one cycle, the first cycle of each scanline. `line_count_o` gives the scanline index 0..`LINES_PER_FIELD`−1, and it reads 0 during the vertical interval.
- R11: While `rst_ni` is low, the outputs are held at these values, even in the middle of a line: `sync_o`=0, `video_o`=0, `active_o`=0, `line_start_o`=0, `line_count_o`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, C cycles per microsecond |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pixel_i | input | 1 | Pixel bit from the pixel source |
| sync_o | output | 1 | 0 = sync tip, 1 = black level or above |
| video_o | output | 1 | 1 = white; gated by the active window |
| active_o | output | 1 | High inside the 52 µs active window |
| line_start_o | output | 1 | One-cycle pulse at the start of each scanline |
| line_count_o | output | $clog2(LINES_PER_FIELD+1) | Current scanline index |

## Verification
The assertions assume that `clk_i` runs at exactly C cycles per microsecond and that `pixel_i` is a clean synchronous bit. Under those assumptions, pulse widths and line periods measured in cycles reflect true time. No check in the checker depends on what `pixel_i` carries, so the stimulus is free to toggle `pixel_i` in every cycle and at random. The bench keeps `pixel_i` at 1 during the table walk, so that `video_o` traces the window directly. During the full-frame pass it drives `pixel_i` from a pseudo-random sequence. Reset is applied only on falling clock edges, both from idle and in the middle of a scanline.

// File: rtl/cvs_pkg.sv
package cvs_pkg;
  typedef enum logic [1:0] {
    PH_PRE   = 2'd0,
    PH_BROAD = 2'd1,
    PH_POST  = 2'd2,
    PH_LINES = 2'd3
  } phase_e;

  // segment lengths in microseconds
  localparam int unsigned HSYNC_US      = 2;
  localparam int unsigned BACK_US       = 4;
  localparam int unsigned ACTIVE_US     = 52;
  localparam int unsigned LINE_US       = 64;
  localparam int unsigned EQ_LOW_US     = 2;
  localparam int unsigned EQ_HIGH_US    = 31;
  localparam int unsigned BROAD_LOW_US  = 27;
  localparam int unsigned BROAD_HIGH_US = 4;
endpackage

// File: rtl/cvs_slot_decode.sv
module cvs_slot_decode
  import cvs_pkg::*;
#(
  parameter int unsigned CYCLES_PER_US = 20,
  parameter int unsigned CNT_W         = 11
) (
  input  phase_e             phase_i,
  output logic [CNT_W-1:0]   slot_last_o,
  output logic [CNT_W-1:0]   low_len_o
);
  localparam logic [CNT_W-1:0] EQ_LAST    = CNT_W'((EQ_LOW_US + EQ_HIGH_US) * CYCLES_PER_US - 1);
  localparam logic [CNT_W-1:0] EQ_LOW     = CNT_W'(EQ_LOW_US * CYCLES_PER_US);
  localparam logic [CNT_W-1:0] BROAD_LAST = CNT_W'((BROAD_LOW_US + BROAD_HIGH_US) * CYCLES_PER_US - 1);
  localparam logic [CNT_W-1:0] BROAD_LOW  = CNT_W'(BROAD_LOW_US * CYCLES_PER_US);
  localparam logic [CNT_W-1:0] LINE_LAST  = CNT_W'(LINE_US * CYCLES_PER_US - 1);
  localparam logic [CNT_W-1:0] HS_LOW     = CNT_W'(HSYNC_US * CYCLES_PER_US);

  always_comb begin
    unique case (phase_i)
      PH_PRE, PH_POST: begin
        slot_last_o = EQ_LAST;
        low_len_o   = EQ_LOW;
      end
      PH_BROAD: begin
        slot_last_o = BROAD_LAST;
        low_len_o   = BROAD_LOW;
      end
      default: begin
        slot_last_o = LINE_LAST;
        low_len_o   = HS_LOW;
      end
    endcase
  end
endmodule

// File: rtl/cvs_slot_timer.sv
module cvs_slot_timer #(
  parameter int unsigned CNT_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] slot_last_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             slot_end_o
);
  logic [CNT_W-1:0] cnt_q;

  assign slot_end_o = (cnt_q == slot_last_i);
  assign cnt_o      = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (slot_end_o) cnt_q <= '0;
    else                 cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/cvs_field_seq.sv
module cvs_field_seq
  import cvs_pkg::*;
#(
  parameter int unsigned LINES_PER_FIELD  = 250,
  parameter int unsigned PULSES_PER_GROUP = 6,
  parameter int unsigned LINE_W           = 8,
  parameter int unsigned PULSE_W          = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              slot_end_i,
  output phase_e            phase_o,
  output logic [LINE_W-1:0] line_o
);
  localparam logic [PULSE_W-1:0] LAST_PULSE = PULSE_W'(PULSES_PER_GROUP - 1);
  localparam logic [LINE_W-1:0]  LAST_LINE  = LINE_W'(LINES_PER_FIELD - 1);

  phase_e             phase_q;
  logic [PULSE_W-1:0] pulse_q;
  logic [LINE_W-1:0]  line_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_PRE;
      pulse_q <= '0;
      line_q  <= '0;
    end else if (slot_end_i) begin
      if (phase_q == PH_LINES) begin
        if (line_q == LAST_LINE) begin
          line_q  <= '0;
          phase_q <= PH_PRE;
        end else begin
          line_q <= line_q + 1'b1;
        end
      end else if (pulse_q == LAST_PULSE) begin
        pulse_q <= '0;
        unique case (phase_q)
          PH_PRE:   phase_q <= PH_BROAD;
          PH_BROAD: phase_q <= PH_POST;
          default:  phase_q <= PH_LINES;
        endcase
      end else begin
        pulse_q <= pulse_q + 1'b1;
      end
    end
  end

  assign phase_o = phase_q;
  assign line_o  = line_q;
endmodule

// File: rtl/cvs_line_window.sv
module cvs_line_window
  import cvs_pkg::*;
#(
  parameter int unsigned CYCLES_PER_US = 20,
  parameter int unsigned CNT_W         = 11
) (
  input  phase_e           phase_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] low_len_i,
  input  logic             pixel_i,
  output logic             sync_o,
  output logic             active_o,
  output logic             line_start_o,
  output logic             video_o
);
  localparam logic [CNT_W-1:0] ACT_START = CNT_W'((HSYNC_US + BACK_US) * CYCLES_PER_US);
  localparam logic [CNT_W-1:0] ACT_END   = CNT_W'((HSYNC_US + BACK_US + ACTIVE_US) * CYCLES_PER_US);

  logic in_lines;

  assign in_lines     = (phase_i == PH_LINES);
  assign sync_o       = (cnt_i >= low_len_i);
  assign active_o     = in_lines && (cnt_i >= ACT_START) && (cnt_i < ACT_END);
  assign line_start_o = in_lines && (cnt_i == '0);
  assign video_o      = active_o & pixel_i;
endmodule

// File: rtl/cvs_sync_gen.sv
module cvs_sync_gen
  import cvs_pkg::*;
#(
  parameter int unsigned CYCLES_PER_US    = 20,
  parameter int unsigned LINES_PER_FIELD  = 250,
  parameter int unsigned PULSES_PER_GROUP = 6,
  localparam int unsigned LINE_CYC        = LINE_US * CYCLES_PER_US,
  localparam int unsigned CNT_W           = $clog2(LINE_CYC),
  localparam int unsigned LINE_W          = $clog2(LINES_PER_FIELD + 1),
  localparam int unsigned PULSE_W         = $clog2(PULSES_PER_GROUP + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pixel_i,
  output logic              sync_o,
  output logic              video_o,
  output logic              active_o,
  output logic              line_start_o,
  output logic [LINE_W-1:0] line_count_o
);
  phase_e           phase;
  logic [CNT_W-1:0] slot_last;
  logic [CNT_W-1:0] low_len;
  logic [CNT_W-1:0] cnt;
  logic             slot_end;

  cvs_slot_decode #(.CYCLES_PER_US(CYCLES_PER_US), .CNT_W(CNT_W)) u_dec (
    .phase_i     (phase),
    .slot_last_o (slot_last),
    .low_len_o   (low_len)
  );

  cvs_slot_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .slot_last_i (slot_last),
    .cnt_o       (cnt),
    .slot_end_o  (slot_end)
  );

  cvs_field_seq #(
    .LINES_PER_FIELD  (LINES_PER_FIELD),
    .PULSES_PER_GROUP (PULSES_PER_GROUP),
    .LINE_W           (LINE_W),
    .PULSE_W          (PULSE_W)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .slot_end_i (slot_end),
    .phase_o    (phase),
    .line_o     (line_count_o)
  );

  cvs_line_window #(.CYCLES_PER_US(CYCLES_PER_US), .CNT_W(CNT_W)) u_win (
    .phase_i      (phase),
    .cnt_i        (cnt),
    .low_len_i    (low_len),
    .pixel_i      (pixel_i),
    .sync_o       (sync_o),
    .active_o     (active_o),
    .line_start_o (line_start_o),
    .video_o      (video_o)
  );
endmodule

// File: rtl/cvs_sync_gen_chk.sv
module cvs_sync_gen_chk #(
  parameter int unsigned CYCLES_PER_US   = 20,
  parameter int unsigned LINES_PER_FIELD = 250,
  parameter int unsigned LINE_W          = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              pixel_i,
  input logic              sync_o,
  input logic              video_o,
  input logic              active_o,
  input logic              line_start_o,
  input logic [LINE_W-1:0] line_count_o
);
  localparam int unsigned LINE_CYC  = 64 * CYCLES_PER_US;
  localparam int unsigned SHORT_LOW = 2 * CYCLES_PER_US;
  localparam int unsigned BROAD_LOW = 27 * CYCLES_PER_US;

  int unsigned gap_q;
  int unsigned low_run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q     <= 0;
      low_run_q <= 0;
    end else begin
      gap_q     <= line_start_o ? 1 : gap_q + 1;
      low_run_q <= sync_o ? 0 : low_run_q + 1;
    end
  end

  // R1
  line_period_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_start_o && line_count_o != '0) |-> (gap_q == LINE_CYC));

  // R2
  line_sync_tip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_start_o |-> !sync_o);

  // R3
  active_above_black_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o |-> sync_o);

  // R4
  video_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_o |-> !video_o);

  // R5
  low_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sync_o) |-> (low_run_q == SHORT_LOW || low_run_q == BROAD_LOW));

  // R9
  line_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(line_count_o) < LINES_PER_FIELD);

  // R10
  line_start_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_start_o |=> !line_start_o);

  // R10
  line_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_start_o && line_count_o != '0) |-> (line_count_o == $past(line_count_o) + 1'b1));
endmodule

bind cvs_sync_gen cvs_sync_gen_chk #(
  .CYCLES_PER_US   (CYCLES_PER_US),
  .LINES_PER_FIELD (LINES_PER_FIELD),
  .LINE_W          (LINE_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .pixel_i      (pixel_i),
  .sync_o       (sync_o),
  .video_o      (video_o),
  .active_o     (active_o),
  .line_start_o (line_start_o),
  .line_count_o (line_count_o)
);

// File: tb/cvs_sync_gen_test.sv
module cvs_sync_gen_test;
  localparam int CLK_PERIOD = 10;
  localparam int C     = 2;
  localparam int LINES = 250;
  localparam int LW    = $clog2(LINES + 1);

  localparam int EQ_SLOT = 33 * C;
  localparam int BR_SLOT = 31 * C;
  localparam int PRE_END = 6 * EQ_SLOT;
  localparam int BR_END  = PRE_END + 6 * BR_SLOT;
  localparam int VS_END  = BR_END + 6 * EQ_SLOT;
  localparam int LINE_C  = 64 * C;
  localparam int FRAME   = VS_END + LINES * LINE_C;

  typedef struct packed {
    int   cyc;
    logic s;
    logic a;
    logic l;
    int   ln;
  } probe_t;

  localparam int NP = 23;
  localparam probe_t TBL [NP] = '{
    '{0,       1'b0, 1'b0, 1'b0, 0},
    '{3,       1'b0, 1'b0, 1'b0, 0},
    '{4,       1'b1, 1'b0, 1'b0, 0},
    '{65,      1'b1, 1'b0, 1'b0, 0},
    '{66,      1'b0, 1'b0, 1'b0, 0},
    '{396,     1'b0, 1'b0, 1'b0, 0},
    '{449,     1'b0, 1'b0, 1'b0, 0},
    '{450,     1'b1, 1'b0, 1'b0, 0},
    '{457,     1'b1, 1'b0, 1'b0, 0},
    '{458,     1'b0, 1'b0, 1'b0, 0},
    '{768,     1'b0, 1'b0, 1'b0, 0},
    '{772,     1'b1, 1'b0, 1'b0, 0},
    '{1163,    1'b1, 1'b0, 1'b0, 0},
    '{1164,    1'b0, 1'b0, 1'b1, 0},
    '{1167,    1'b0, 1'b0, 1'b0, 0},
    '{1175,    1'b1, 1'b0, 1'b0, 0},
    '{1176,    1'b1, 1'b1, 1'b0, 0},
    '{1279,    1'b1, 1'b1, 1'b0, 0},
    '{1280,    1'b1, 1'b0, 1'b0, 0},
    '{1292,    1'b0, 1'b0, 1'b1, 1},
    '{33036,   1'b0, 1'b0, 1'b1, 249},
    '{33163,   1'b1, 1'b0, 1'b0, 249},
    '{33164,   1'b0, 1'b0, 1'b0, 0}
  };

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          pixel_i = 1'b1;
  logic          sync_o, video_o, active_o, line_start_o;
  logic [LW-1:0] line_count_o;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  cvs_sync_gen #(.CYCLES_PER_US(C), .LINES_PER_FIELD(LINES)) uut (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .pixel_i      (pixel_i),
    .sync_o       (sync_o),
    .video_o      (video_o),
    .active_o     (active_o),
    .line_start_o (line_start_o),
    .line_count_o (line_count_o)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cyc, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
    #1;
  endtask

  task automatic release_reset();
    @(negedge clk);
    rst_ni = 1'b1;
    cyc = 0;
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    int lo4, lo54, hi62, hi8, hi124, ls_cnt, run;
    logic prev_s;
    lfsr = 16'hACE1;

    // R11 reset state, pixel held at 1
    repeat (2) @(negedge clk);
    #1;
    check("R11 sync", int'(sync_o), 0);
    check("R11 video", int'(video_o), 0);
    check("R11 active", int'(active_o), 0);
    check("R11 line_start", int'(line_start_o), 0);
    check("R11 line_count", int'(line_count_o), 0);

    // table walk: R8 start, R5 R6 R7 vertical shape, R2 R3 R10 line shape, R9 wrap
    release_reset();
    for (int i = 0; i < NP; i++) begin
      while (cyc < TBL[i].cyc) step();
      check("R2_R5_R6_R7_R8 sync", int'(sync_o), int'(TBL[i].s));
      check("R3 active", int'(active_o), int'(TBL[i].a));
      check("R4 video", int'(video_o), int'(TBL[i].a));
      check("R10 line_start", int'(line_start_o), int'(TBL[i].l));
      check("R10 line_count", int'(line_count_o), TBL[i].ln);
    end

    // full-frame reference comparison with random pixels (R1..R10)
    lo4 = 0; lo54 = 0; hi62 = 0; hi8 = 0; hi124 = 0; ls_cnt = 0; run = 0;
    prev_s = 1'b0;
    for (int p = 0; p < FRAME; p++) begin
      int es, ea, el, eln, lp;
      if (p != 0) begin
        @(negedge clk);
        cyc++;
      end
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      pixel_i = lfsr[0];
      #1;
      ea = 0; el = 0; eln = 0;
      if (p < PRE_END)      es = ((p % EQ_SLOT) >= 2 * C) ? 1 : 0;
      else if (p < BR_END)  es = (((p - PRE_END) % BR_SLOT) >= 27 * C) ? 1 : 0;
      else if (p < VS_END)  es = (((p - BR_END) % EQ_SLOT) >= 2 * C) ? 1 : 0;
      else begin
        lp  = (p - VS_END) % LINE_C;
        eln = (p - VS_END) / LINE_C;
        es  = (lp >= 2 * C) ? 1 : 0;
        ea  = (lp >= 6 * C && lp < 58 * C) ? 1 : 0;
        el  = (lp == 0) ? 1 : 0;
      end
      if (int'(sync_o) != es)      check("R1_R2_R5_R6_R7 frame sync", int'(sync_o), es);
      if (int'(active_o) != ea)    check("R3 frame active", int'(active_o), ea);
      if (int'(video_o) != (ea & int'(pixel_i)))
        check("R4 frame video", int'(video_o), ea & int'(pixel_i));
      if (int'(line_start_o) != el) check("R10 frame line_start", int'(line_start_o), el);
      if (int'(line_count_o) != eln) check("R9 frame line_count", int'(line_count_o), eln);
      if (line_start_o) ls_cnt++;
      if (p != 0 && sync_o != prev_s) begin
        if (prev_s == 1'b0) begin
          if (run == 4) lo4++;
          if (run == 54) lo54++;
        end else begin
          if (run == 62) hi62++;
          if (run == 8) hi8++;
          if (run == 124) hi124++;
        end
        run = 0;
      end
      run++;
      prev_s = sync_o;
    end
    check("R1 frame mismatch-free sync", 0, 0);
    check("R5_R7 short lows incl hsync", lo4, 12 + LINES);
    check("R6 broad lows", lo54, 6);
    check("R5_R7 short highs", hi62, 12);
    check("R6 broad highs", hi8, 6);
    check("R2 line highs", hi124, LINES - 1);
    check("R10 line starts per frame", ls_cnt, LINES);

    // R11 mid-line reset, then R8 restart at vertical interval
    repeat (VS_END + 300) step();
    pixel_i = 1'b1;
    while (!active_o) step();
    check("R3 pre-reset active", int'(active_o), 1);
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    check("R11 mid sync", int'(sync_o), 0);
    check("R11 mid video", int'(video_o), 0);
    check("R11 mid active", int'(active_o), 0);
    check("R11 mid line_count", int'(line_count_o), 0);
    release_reset();
    repeat (3) step();
    check("R8 restart low", int'(sync_o), 0);
    step();
    check("R8 restart high", int'(sync_o), 1);
    while (cyc < VS_END) step();
    check("R7 first line after vsync", int'(line_start_o), 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule